// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it receives an operation code, the accumulator value and a second operand. It returns an 8-bit result and a write-enable for the destination, both combinationally. The five condition flags are kept in a register inside the block. That register changes only on a clock edge where the valid strobe is high.

The operations are:
- add and subtract, each with and without the carry flag as an incoming carry or borrow;
- the three bitwise operations;
- compare;
- increment and decrement of the operand;
- ones' complement of the accumulator;
- decimal adjust after a BCD addition;
- four single-bit rotates of the accumulator.

Register selection, instruction fetch and memory access stay with the surrounding datapath. That datapath routes `res_o` to wherever `wr_o` says it belongs.

Top module: `acc_alu`

## Requirements
- R1: op 0 (add) gives acc+opnd and op 1 (add with carry) gives acc+opnd+CY, both mod 256. CY becomes the carry out of bit 7 and AC becomes the carry out of bit 3.
- R2: op 2 (subtract) gives acc-opnd and op 3 (subtract with borrow) gives acc-opnd-CY, both mod 256. CY is set when a borrow occurred. AC is set when the low nibble of acc is smaller than the low nibble of opnd plus the borrow-in.
- R3: op 4 (AND), op 5 (OR) and op 6 (XOR) give the bitwise result of acc and opnd and clear both CY and AC.
- R4: op 7 (compare) sets all five flags exactly as a subtract would, and holds wr_o low.
- R5: op 8 (increment) gives opnd+1 and op 9 (decrement) gives opnd-1, both wrapping mod 256. AC is the carry out of bit 3 for increment and the borrow into bit 4 for decrement. CY is left unchanged.
- R6: op 10 (complement) gives the ones' complement of acc and changes no flag.
- R7: op 11 (decimal adjust) works in two steps.
  - Step one: it adds 0x06 when the low nibble of acc exceeds 9 or AC is set. AC becomes the carry out of bit 3 from this step.
  - Step two: it then adds 0x60 when the high nibble of that intermediate sum exceeds 9, when step one carried out of bit 7, or when CY is set. CY becomes 1 exactly when this second step applies.
- R8: op 12 rotates acc left and op 13 rotates it right. The bit leaving the register enters both the vacated bit and CY. No other flag changes.
- R9: op 14 rotates acc left through carry and op 15 rotates it right through carry. The old CY enters the vacated bit and the bit leaving the register becomes CY. No other flag changes.
- R10: flags_o holds S in bit 4, Z in bit 3, AC in bit 2, P in bit 1 and CY in bit 0. For ops 0 to 9 and 11, S is bit 7 of the result, Z is set when the result is zero, and P is set when the result has an even number of ones.
- R11: an active-low reset clears all flags to 0. The flags change only on a clock edge where valid_i is high.
- R12: wr_o equals valid_i for every op except compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| valid_i | input | 1 | operation strobe; flags update on this edge |
| op_i | input | 4 | operation code |
| acc_i | input | 8 | accumulator value |
| opnd_i | input | 8 | second operand |
| res_o | output | 8 | result (combinational) |
| wr_o | output | 1 | destination write-enable (combinational) |
| flags_o | output | 5 | flag register {S,Z,AC,P,CY} |

## Verification
Arithmetic operations are driven with random operands under both incoming carry values. This separates the with-carry variants from the plain ones, and it also exposes a borrow polarity that is inverted. Boundary operands are applied deliberately: 0x00, 0xFF, 0x0F/0x10 and equal operands. These cover wraparound, nibble carries and the zero flag, and they show increment and decrement leaving a set or clear carry unchanged. Decimal adjust is run on sums that cover each combination of the two corrections. Rotates are run with both carry values, which distinguishes the through-carry pair from the copy pair. A strobe-low cycle with a carry-producing operand shows that the flags are held.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic [4:0]   flags_o
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
                         OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMP = 4'd7,
                         OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_CMA = 4'd10, OP_DAA = 4'd11,
                         OP_RLC = 4'd12, OP_RRC = 4'd13, OP_RAL = 4'd14, OP_RAR = 4'd15;
  localparam int H = W / 2;

  logic cy, ac;
  assign cy = flags_o[0];
  assign ac = flags_o[2];

  logic         cin, bin;
  logic [W:0]   sum, dif;
  logic [H:0]   hsum, hdif;
  assign cin  = (op_i == OP_ADC) & cy;
  assign bin  = (op_i == OP_SBB) & cy;
  assign sum  = {1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, cin};
  assign dif  = {1'b0, acc_i} - {1'b0, opnd_i} - {{W{1'b0}}, bin};
  assign hsum = {1'b0, acc_i[H-1:0]} + {1'b0, opnd_i[H-1:0]} + {{H{1'b0}}, cin};
  assign hdif = {1'b0, acc_i[H-1:0]} - {1'b0, opnd_i[H-1:0]} - {{H{1'b0}}, bin};

  logic         lo_fix, hi_fix;
  logic [H:0]   dlo;
  logic [W:0]   t1;
  logic [W-1:0] dres;
  assign lo_fix = (acc_i[H-1:0] > 4'd9) | ac;
  assign dlo    = {1'b0, acc_i[H-1:0]} + (lo_fix ? 5'd6 : 5'd0);
  assign t1     = {1'b0, acc_i} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix = (t1[W-1:H] > 4'd9) | t1[W] | cy;
  assign dres   = t1[W-1:0] + (hi_fix ? 8'h60 : 8'h00);

  logic [W-1:0] r;
  logic         ncy, nac;
  logic         szp_upd;

  always_comb begin
    r       = acc_i;
    ncy     = cy;
    nac     = ac;
    szp_upd = 1'b1;
    unique case (op_i)
      OP_ADD, OP_ADC: begin r = sum[W-1:0]; ncy = sum[W]; nac = hsum[H]; end
      OP_SUB, OP_SBB, OP_CMP: begin r = dif[W-1:0]; ncy = dif[W]; nac = hdif[H]; end
      OP_AND: begin r = acc_i & opnd_i; ncy = 1'b0; nac = 1'b0; end
      OP_OR:  begin r = acc_i | opnd_i; ncy = 1'b0; nac = 1'b0; end
      OP_XOR: begin r = acc_i ^ opnd_i; ncy = 1'b0; nac = 1'b0; end
      OP_INC: begin r = opnd_i + 1'b1; nac = (opnd_i[H-1:0] == {H{1'b1}}); end
      OP_DEC: begin r = opnd_i - 1'b1; nac = (opnd_i[H-1:0] == {H{1'b0}}); end
      OP_CMA: begin r = ~acc_i; szp_upd = 1'b0; end
      OP_DAA: begin r = dres; ncy = hi_fix; nac = dlo[H]; end
      OP_RLC: begin r = {acc_i[W-2:0], acc_i[W-1]}; ncy = acc_i[W-1]; szp_upd = 1'b0; end
      OP_RRC: begin r = {acc_i[0], acc_i[W-1:1]};   ncy = acc_i[0];   szp_upd = 1'b0; end
      OP_RAL: begin r = {acc_i[W-2:0], cy};         ncy = acc_i[W-1]; szp_upd = 1'b0; end
      OP_RAR: begin r = {cy, acc_i[W-1:1]};         ncy = acc_i[0];   szp_upd = 1'b0; end
      default: ;
    endcase
  end

  assign res_o = r;
  assign wr_o  = valid_i & (op_i != OP_CMP);

  logic [4:0] nflags;
  assign nflags = szp_upd ? {r[W-1], (r == '0), nac, ~^r, ncy}
                          : {flags_o[4:3], nac, flags_o[1], ncy};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flags_o <= '0;
    else if (valid_i) flags_o <= nflags;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic [3:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] res_o,
  input logic       wr_o,
  input logic [4:0] flags_o
);
  // R4
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd7) |-> !wr_o);
  // R11
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o));
  // R5
  incdec_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 4'd8 || op_i == 4'd9)) |=> flags_o[0] == $past(flags_o[0]));
  // R6
  cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd10) |=> $stable(flags_o));
  // R3
  logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6)) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));
  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i <= 4'd9 || op_i == 4'd11)) |=> flags_o[3] == ($past(res_o) == 8'h00));
  // R8
  rlc_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd12) |=> flags_o[0] == $past(acc_i[7]));
  // R12
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !wr_o);
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .acc_i(acc_i),
  .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [7:0] res_o;
  logic       wr_o;
  logic [4:0] flags_o;

  int errors = 0, checks = 0;
  logic [4:0] mf;

  acc_alu dut (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .acc_i(acc_i),
               .opnd_i(opnd_i), .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                        input logic [4:0] f);
    logic [8:0] t; logic [7:0] r; logic cy, ac, szp, lo, hi; int v;
    cy = f[0]; ac = f[2]; szp = 1'b1; r = a;
    case (op)
      0, 1: begin v = a + b + ((op == 1) ? int'(f[0]) : 0); r = v[7:0]; cy = v > 255;
              ac = (a % 16 + b % 16 + ((op == 1) ? int'(f[0]) : 0)) > 15; end
      2, 3, 7: begin v = int'(a) - int'(b) - ((op == 3) ? int'(f[0]) : 0); r = v[7:0]; cy = v < 0;
              ac = int'(a % 16) < int'(b % 16) + ((op == 3) ? int'(f[0]) : 0); end
      4: begin r = a & b; cy = 0; ac = 0; end
      5: begin r = a | b; cy = 0; ac = 0; end
      6: begin r = a ^ b; cy = 0; ac = 0; end
      8: begin r = b + 8'd1; ac = (b % 16) == 15; end
      9: begin r = b - 8'd1; ac = (b % 16) == 0; end
      10: begin r = ~a; szp = 0; end
      11: begin lo = (a % 16 > 9) || f[2]; v = a + (lo ? 6 : 0); ac = lo && (a % 16 + 6 > 15);
            hi = ((v / 16) % 16 > 9) || v > 255 || f[0]; v = v + (hi ? 96 : 0); r = v[7:0]; cy = hi; end
      12: begin r = {a[6:0], a[7]}; cy = a[7]; szp = 0; end
      13: begin r = {a[0], a[7:1]}; cy = a[0]; szp = 0; end
      14: begin r = {a[6:0], f[0]}; cy = a[7]; szp = 0; end
      default: begin r = {f[0], a[7:1]}; cy = a[0]; szp = 0; end
    endcase
    t[0] = (op != 7);
    return {t[0], r, szp ? r[7] : f[4], szp ? (r == 0) : f[3], ac, szp ? ~^r : f[1], cy};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input string tag, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [13:0] e;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; acc_i = a; opnd_i = b;
    e = model(op, a, b, mf);
    #1;
    check(tag, "wr", wr_o, e[13]);
    check(tag, "res", res_o, e[12:5]);
    @(posedge clk); #1;
    mf = e[4:0];
    check(tag, "flags", flags_o, mf);
    valid_i = 1'b0;
  endtask

  task automatic set_cy(input logic c);
    if (c) do_op("R1", 4'd0, 8'hFF, 8'h01); else do_op("R1", 4'd0, 8'h00, 8'h00);
  endtask

  task automatic t_reset;
    #1; check("R11", "reset flags", flags_o, 0);
    check("R12", "reset wr", wr_o, 0);
  endtask

  task automatic t_arith;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 40; i++) begin
        set_cy(c[0]); do_op("R1", 4'd1, 8'($urandom), 8'($urandom));
        set_cy(c[0]); do_op("R2", 4'd3, 8'($urandom), 8'($urandom));
        do_op("R1", 4'd0, 8'($urandom), 8'($urandom));
        do_op("R2", 4'd2, 8'($urandom), 8'($urandom));
      end
    do_op("R1", 4'd0, 8'h0F, 8'h01); do_op("R1", 4'd0, 8'h80, 8'h80);
    do_op("R2", 4'd2, 8'h10, 8'h01); do_op("R2", 4'd2, 8'h05, 8'h05);
    set_cy(1); do_op("R2", 4'd3, 8'h05, 8'h05);
  endtask

  task automatic t_logic;
    for (int i = 0; i < 30; i++) begin
      set_cy(1); do_op("R3", 4'd4, 8'($urandom), 8'($urandom));
      set_cy(1); do_op("R3", 4'd5, 8'($urandom), 8'($urandom));
      set_cy(1); do_op("R3", 4'd6, 8'($urandom), 8'($urandom));
    end
    do_op("R10", 4'd6, 8'h5A, 8'h5A);
  endtask

  task automatic t_cmp;
    for (int i = 0; i < 30; i++) do_op("R4", 4'd7, 8'($urandom), 8'($urandom));
    do_op("R4", 4'd7, 8'h33, 8'h33); do_op("R4", 4'd7, 8'h01, 8'h02);
  endtask

  task automatic t_incdec;
    for (int c = 0; c < 2; c++) begin
      set_cy(c[0]); do_op("R5", 4'd8, 8'hFF, 8'h00);
      set_cy(c[0]); do_op("R5", 4'd9, 8'h00, 8'h00);
      set_cy(c[0]); do_op("R5", 4'd8, 8'h00, 8'h0F);
      set_cy(c[0]); do_op("R5", 4'd9, 8'h00, 8'h10);
      for (int i = 0; i < 10; i++) begin
        do_op("R5", 4'd8, 8'($urandom), 8'($urandom)); do_op("R5", 4'd9, 8'($urandom), 8'($urandom));
      end
    end
  endtask

  task automatic t_cma;
    set_cy(1); do_op("R6", 4'd10, 8'hA5, 8'h00);
    do_op("R6", 4'd10, 8'h00, 8'h00); do_op("R6", 4'd10, 8'hFF, 8'h00);
  endtask

  task automatic t_daa;
    for (int i = 0; i < 40; i++) begin
      int x, y; x = $urandom_range(0, 99); y = $urandom_range(0, 99);
      do_op("R7", 4'd0, 8'((x / 10) * 16 + x % 10), 8'((y / 10) * 16 + y % 10));
      do_op("R7", 4'd11, res_o, 8'h00);
    end
    do_op("R7", 4'd0, 8'h09, 8'h09); do_op("R7", 4'd11, 8'h12, 8'h00);
    do_op("R7", 4'd0, 8'h99, 8'h99); do_op("R7", 4'd11, 8'h32, 8'h00);
    do_op("R7", 4'd0, 8'h00, 8'h00); do_op("R7", 4'd11, 8'h9A, 8'h00);
    do_op("R7", 4'd0, 8'h00, 8'h00); do_op("R7", 4'd11, 8'hA5, 8'h00);
  endtask

  task automatic t_rot;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) begin
        set_cy(c[0]); do_op("R8", 4'd12, 8'($urandom), 8'h00);
        set_cy(c[0]); do_op("R8", 4'd13, 8'($urandom), 8'h00);
        set_cy(c[0]); do_op("R9", 4'd14, 8'($urandom), 8'h00);
        set_cy(c[0]); do_op("R9", 4'd15, 8'($urandom), 8'h00);
      end
  endtask

  task automatic t_idle;
    set_cy(0);
    @(negedge clk);
    valid_i = 1'b0; op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'h01;
    #1; check("R12", "wr idle", wr_o, 0);
    @(posedge clk); #1;
    check("R11", "flags held", flags_o, mf);
  endtask

  initial begin
    mf = '0;
    t_reset;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_arith; t_logic; t_cmp; t_incdec; t_cma; t_daa; t_rot; t_idle;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule